// File: doc/BRIEF.md
# Debug Receive Mailbox Handshake Register

This block is a one-word receive mailbox between an external debug host and debug software running on the chip. The host loads a data word through a simple scan-side write strobe, and can also change a transmit-ready status bit and clear an overflow record. Software sees two addresses on a small read/write port: a status/control word and the received data word.

A ready flag lets the two sides take turns. A host load raises the flag, and a software read of the data word drops it. In normal operation both sides poll the flag before they act. In high-speed download operation, software sets a mode bit and the host streams words without polling, so only software polls. Any word that overwrites one that software has not yet read is recorded in a sticky overflow flag. Only the host can clear that flag.

The software read data is combinational from the selected register. Side effects happen only on the clock edge where the read strobe is high.

Top module: `dbg_rx_mailbox`

## Requirements
- R1: After reset, the status word reads 0x00000000 and the data word reads 0x00000000.
- R2: The status word (sw_addr = 0) places ready at bit 31, overflow at bit 30, the high-speed download mode at bit 29 and transmit-ready at bit 28. Bits 27:0 always read as zero.
- R3: A cycle with host_wr high loads host_data into the data word (sw_addr = 1) and leaves ready set on the next cycle.
- R4: A cycle with sw_rd high and sw_addr = 1, and without host_wr, clears ready on the next cycle and leaves the data word unchanged.
- R5: A host_wr that arrives while ready is set still replaces the data word and keeps ready set. It also sets overflow.
- R6: Overflow stays set through any software read or write. Only a cycle with host_clr_ovf high clears it. When that clear coincides with an overflowing host_wr, overflow stays set.
- R7: When host_wr and a software data read (sw_rd, sw_addr = 1) occur in the same cycle, the write wins: ready ends the cycle set and the data word holds the new value.
- R8: A software write (sw_wr) to sw_addr = 0 loads bit 29 of sw_wdata into the high-speed mode bit. Its bits 31, 30, 28 and 27:0 are ignored.
- R9: A cycle with host_tx_we high loads host_tx_val into transmit-ready. Software cannot change transmit-ready.
- R10: A software write to sw_addr = 1 is ignored. A software read of sw_addr = 0 changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_wr | input | 1 | Host load strobe, with data valid |
| host_data | input | 32 | Host data word |
| host_clr_ovf | input | 1 | Host clear of the overflow flag |
| host_tx_we | input | 1 | Host write strobe for transmit-ready |
| host_tx_val | input | 1 | Value for transmit-ready |
| sw_addr | input | 1 | 0 selects status word, 1 selects data word |
| sw_rd | input | 1 | Software read strobe |
| sw_wr | input | 1 | Software write strobe |
| sw_wdata | input | 32 | Software write data |
| sw_rdata | output | 32 | Read data of the selected register |

## Verification
The bench aims at the collisions. It drives a host load against a software data read in the same cycle: a design that let the read win would drop ready and lose a valid word. It drives an overflow clear together with an overflowing load: a design that gave the clear priority would hide a lost word. It also writes all-ones to the status word, and writes to the data address. A design that leaked those writes into ready, overflow, transmit-ready, the reserved bits or the data word shows it at the next status read. Random traffic mixes all of these against a bench model.

// File: rtl/dbgmb_pkg.sv
`timescale 1ns/1ps
package dbgmb_pkg;
  localparam int unsigned WORD_W = 32;
  localparam int unsigned FLAG_N = 4;

  typedef struct packed {
    logic rdy;
    logic ovf;
    logic hs;
    logic tx;
  } mb_flags_t;

  // overflow: set by a load on a full mailbox, set beats clear
  function automatic logic ovf_next(logic cur, logic clr, logic load, logic full);
    return (cur & ~clr) | (load & full);
  endfunction

  // ready: load beats drain
  function automatic logic rdy_next(logic cur, logic load, logic drain);
    return load | (cur & ~drain);
  endfunction
endpackage

// File: rtl/dbgmb_rx_hold.sv
`timescale 1ns/1ps
module dbgmb_rx_hold #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic [DATA_W-1:0] host_data,
  input  logic              host_clr_ovf,
  input  logic              sw_rx_rd,
  output logic [DATA_W-1:0] rx_data,
  output logic              rdy,
  output logic              ovf
);
  import dbgmb_pkg::*;

  logic rx_load, rx_drain, ovf_event;
  assign rx_load   = host_wr;
  assign rx_drain  = sw_rx_rd;
  assign ovf_event = host_wr & rdy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_data <= '0;
      rdy     <= 1'b0;
      ovf     <= 1'b0;
    end else begin
      if (rx_load) rx_data <= host_data;
      rdy <= rdy_next(rdy, rx_load, rx_drain);
      ovf <= ovf_next(ovf, host_clr_ovf, rx_load, rdy);
    end
  end

  a_r3_load_sets_ready: assert property (@(posedge clk) disable iff (!rst_n)
    rx_load |=> rdy);
  a_r3_load_data: assert property (@(posedge clk) disable iff (!rst_n)
    rx_load |=> (rx_data == $past(host_data)));
  a_r4_drain_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_drain && !rx_load) |=> (!rdy && $stable(rx_data)));
  a_r5_overwrite_flags: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_event |=> ovf);
  a_r6_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovf && !host_clr_ovf) |=> ovf);
  a_r6_ovf_only_event: assert property (@(posedge clk) disable iff (!rst_n)
    (!ovf && !ovf_event) |=> !ovf);
endmodule

// File: rtl/dbgmb_ctl_bits.sv
`timescale 1ns/1ps
module dbgmb_ctl_bits (
  input  logic clk,
  input  logic rst_n,
  input  logic sw_ctl_wr,
  input  logic sw_hs_val,
  input  logic host_tx_we,
  input  logic host_tx_val,
  output logic hs,
  output logic tx
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hs <= 1'b0;
      tx <= 1'b0;
    end else begin
      if (sw_ctl_wr)  hs <= sw_hs_val;
      if (host_tx_we) tx <= host_tx_val;
    end
  end

  a_r8_hs_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_ctl_wr |=> $stable(hs));
  a_r9_tx_holds: assert property (@(posedge clk) disable iff (!rst_n)
    !host_tx_we |=> $stable(tx));
  a_r9_tx_loads: assert property (@(posedge clk) disable iff (!rst_n)
    host_tx_we |=> (tx == $past(host_tx_val)));
endmodule

// File: rtl/dbgmb_rdmux.sv
`timescale 1ns/1ps
module dbgmb_rdmux #(
  parameter int unsigned DATA_W = 32
) (
  input  logic                  sel_data,
  input  dbgmb_pkg::mb_flags_t  flags,
  input  logic [DATA_W-1:0]     rx_data,
  output logic [DATA_W-1:0]     rdata
);
  import dbgmb_pkg::*;
  localparam int unsigned RSV_W = DATA_W - FLAG_N;

  logic [DATA_W-1:0] status_word;
  assign status_word = {flags, {RSV_W{1'b0}}};
  assign rdata = sel_data ? rx_data : status_word;
endmodule

// File: rtl/dbg_rx_mailbox.sv
`timescale 1ns/1ps
module dbg_rx_mailbox #(
  parameter int unsigned DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_wr,
  input  logic [DATA_W-1:0] host_data,
  input  logic              host_clr_ovf,
  input  logic              host_tx_we,
  input  logic              host_tx_val,
  input  logic              sw_addr,
  input  logic              sw_rd,
  input  logic              sw_wr,
  input  logic [DATA_W-1:0] sw_wdata,
  output logic [DATA_W-1:0] sw_rdata
);
  import dbgmb_pkg::*;
  localparam int unsigned HS_BIT = DATA_W - 3;
  localparam int unsigned RSV_W  = DATA_W - FLAG_N;

  logic      sw_rx_rd, sw_ctl_wr;
  mb_flags_t flags;
  logic [DATA_W-1:0] rx_data;
  logic      rdy, ovf, hs, tx;

  assign sw_rx_rd  = sw_rd & sw_addr;
  assign sw_ctl_wr = sw_wr & ~sw_addr;
  assign flags     = '{rdy: rdy, ovf: ovf, hs: hs, tx: tx};

  logic unused_wdata;
  assign unused_wdata = ^{sw_wdata[DATA_W-1:HS_BIT+1], sw_wdata[HS_BIT-1:0]};

  dbgmb_rx_hold #(.DATA_W(DATA_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_data(host_data),
    .host_clr_ovf(host_clr_ovf), .sw_rx_rd(sw_rx_rd),
    .rx_data(rx_data), .rdy(rdy), .ovf(ovf)
  );

  dbgmb_ctl_bits u_ctl (
    .clk(clk), .rst_n(rst_n), .sw_ctl_wr(sw_ctl_wr), .sw_hs_val(sw_wdata[HS_BIT]),
    .host_tx_we(host_tx_we), .host_tx_val(host_tx_val), .hs(hs), .tx(tx)
  );

  dbgmb_rdmux #(.DATA_W(DATA_W)) u_mux (
    .sel_data(sw_addr), .flags(flags), .rx_data(rx_data), .rdata(sw_rdata)
  );

  a_r2_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !sw_addr |-> (sw_rdata[RSV_W-1:0] == '0));
  a_r7_write_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (host_wr && sw_rx_rd) |=> rdy);
  a_r10_data_wr_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_wr && sw_addr && !host_wr) |=> $stable(rx_data));
endmodule

// File: tb/sim_dbg_rx_mailbox.sv
`timescale 1ns/1ps
module sim_dbg_rx_mailbox;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic host_wr = 0, host_clr_ovf = 0, host_tx_we = 0, host_tx_val = 0;
  logic [31:0] host_data = '0;
  logic sw_addr = 0, sw_rd = 0, sw_wr = 0;
  logic [31:0] sw_wdata = '0;
  logic [31:0] sw_rdata;

  int total = 0, fails = 0;
  bit done = 0;
  logic m_rdy = 0, m_ovf = 0, m_hs = 0, m_tx = 0;
  logic [31:0] m_data = '0;

  always #10 clk = ~clk;

  dbg_rx_mailbox u0 (
    .clk(clk), .rst_n(rst_n), .host_wr(host_wr), .host_data(host_data),
    .host_clr_ovf(host_clr_ovf), .host_tx_we(host_tx_we), .host_tx_val(host_tx_val),
    .sw_addr(sw_addr), .sw_rd(sw_rd), .sw_wr(sw_wr), .sw_wdata(sw_wdata),
    .sw_rdata(sw_rdata)
  );

  function automatic logic [31:0] exp_status();
    logic [31:0] w = 32'h0;
    w[31] = m_rdy; w[30] = m_ovf; w[29] = m_hs; w[28] = m_tx;
    return w;
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic peek(string tag);
    sw_addr = 1'b0; #1;
    check({tag, " status"}, sw_rdata, exp_status());
    sw_addr = 1'b1; #1;
    check({tag, " data"}, sw_rdata, m_data);
  endtask

  // one clock cycle of stimulus, called at a falling edge
  task automatic step(string tag, bit hw, logic [31:0] hd, bit hclr, bit txwe, bit txv,
                      bit srd, bit swr, bit addr, logic [31:0] swd);
    host_wr = hw; host_data = hd; host_clr_ovf = hclr;
    host_tx_we = txwe; host_tx_val = txv;
    sw_rd = srd; sw_wr = swr; sw_addr = addr; sw_wdata = swd;
    #1;
    if (srd) check({tag, " rdata"}, sw_rdata, addr ? m_data : exp_status());
    @(posedge clk);
    begin
      logic n_ovf, n_rdy;
      n_ovf = hclr ? 1'b0 : m_ovf;
      if (hw && m_rdy) n_ovf = 1'b1;
      if (hw) n_rdy = 1'b1;
      else if (srd && addr) n_rdy = 1'b0;
      else n_rdy = m_rdy;
      m_ovf = n_ovf; m_rdy = n_rdy;
      if (hw) m_data = hd;
      if (swr && !addr) m_hs = swd[29];
      if (txwe) m_tx = txv;
    end
    @(negedge clk);
    host_wr = 0; host_clr_ovf = 0; host_tx_we = 0; sw_rd = 0; sw_wr = 0;
    peek(tag);
  endtask

  initial begin
    #(20 * 150000);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    peek("R1 reset");
    step("R3 load", 1, 32'hCAFE_0001, 0, 0, 0, 0, 0, 0, 0);
    step("R10 status read no effect", 0, 0, 0, 0, 0, 1, 0, 0, 0);
    step("R4 drain", 0, 0, 0, 0, 0, 1, 0, 1, 0);
    step("R4 drain while empty", 0, 0, 0, 0, 0, 1, 0, 1, 0);
    step("R3 reload", 1, 32'h1111_2222, 0, 0, 0, 0, 0, 0, 0);
    step("R5 overwrite", 1, 32'h3333_4444, 0, 0, 0, 0, 0, 0, 0);
    step("R6 sticky after read", 0, 0, 0, 0, 0, 1, 0, 1, 0);
    step("R6 sticky after sw write", 0, 0, 0, 0, 0, 0, 1, 0, 32'hFFFF_FFFF);
    step("R6 host clear", 0, 0, 1, 0, 0, 0, 0, 0, 0);
    step("R7 load", 1, 32'h0000_00A5, 0, 0, 0, 0, 0, 0, 0);
    step("R7 load+read", 1, 32'h0000_005A, 0, 0, 0, 1, 0, 1, 0);
    step("R6 clear+overflow", 1, 32'h7777_0000, 1, 0, 0, 0, 0, 0, 0);
    step("R8 hs clear all-zero", 0, 0, 0, 0, 0, 0, 1, 0, 32'h0);
    step("R8 hs only bit29", 0, 0, 0, 0, 0, 0, 1, 0, 32'h2000_0000);
    step("R2 reserved write ignored", 0, 0, 0, 0, 0, 0, 1, 0, 32'hDFFF_FFFF);
    step("R9 tx set", 0, 0, 0, 1, 1, 0, 0, 0, 0);
    step("R9 sw cannot clear tx", 0, 0, 0, 0, 0, 0, 1, 0, 32'h0000_0000);
    step("R9 tx clear", 0, 0, 0, 1, 0, 0, 0, 0, 0);
    step("R10 data write ignored", 0, 0, 0, 0, 0, 0, 1, 1, 32'hDEAD_BEEF);
    step("R4 drain", 0, 0, 0, 0, 0, 1, 0, 1, 0);
    step("R6 host clear", 0, 0, 1, 0, 0, 0, 0, 0, 0);
    // high-speed streaming: host loads every other cycle, software drains between
    step("R8 hs on", 0, 0, 0, 0, 0, 0, 1, 0, 32'h2000_0000);
    for (int i = 0; i < 8; i++) begin
      step("R3 stream load", 1, 32'hA000_0000 + i, 0, 0, 0, 0, 0, 0, 0);
      step("R4 stream drain", 0, 0, 0, 0, 0, 1, 0, 1, 0);
    end
    for (int i = 0; i < 400; i++) begin
      logic [31:0] r;
      r = $urandom;
      step("R5 random", r[0] & r[1], $urandom, r[2] & r[3] & r[4], r[5] & r[6], r[7],
           r[8], r[9] & r[10], r[11], $urandom);
    end
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    m_rdy = 0; m_ovf = 0; m_hs = 0; m_tx = 0; m_data = '0;
    peek("R1 second reset");
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule